// File: doc/BRIEF.md
# Systolic Matrix Multiply Grid

This block multiplies two square unsigned matrices, C = A·B, on an N×N grid of multiply-accumulate cells. The caller presents one column of A and one row of B per clock for N consecutive clocks; the first of those clocks is marked with `start`. Inside the block, lane l of each operand bus is delayed by l clocks, so that matching operands meet in the right cell. A operands then step one cell to the right per clock and B operands one cell down. Operands that leave the right or bottom edge are discarded. All cells compute on every clock, and no cell reaches beyond its nearest neighbours.

Each A operand carries two tag bits. One tag marks the first beat of a multiply, and on that beat the cell restarts its sum. The other tag marks the last beat, and on that beat the cell copies its finished sum into a per-cell result register. The result registers of each grid row form a chain that shifts toward the left edge. Row r of C therefore leaves on output lane r one column at a time, column 0 first. Each word on a lane comes with its own valid bit.

A new multiply may begin while the results of the previous one are still leaving the grid, provided its start comes at least 2N clocks after the previous start.

Top module: `systolic_mm_grid`

## Requirements
- R1: While reset is asserted, and after reset until the first `start`, every bit of `c_valid` and `c_out` is 0, whatever is on the operand lanes.
- R2: In beat k (the start clock is beat 0, k = 0..N-1), bits [l*DW +: DW] of `a_col` carry A[l][k] and bits [l*DW +: DW] of `b_row` carry B[k][l]. Lane r of `c_out`, bits [r*AW +: AW], delivers C[r][j] = sum over k of A[r][k]·B[k][j], as an unsigned value.
- R3: If `start` is high in clock 0, lane r shows C[r][j] with `c_valid[r]` high in clock r + N + 2j, for j = 0..N-1 in ascending order. `c_valid[r]` is low in every other clock and is never high in two consecutive clocks.
- R4: The result width AW = 2·DW + clog2(N) holds N products of all-ones operands without overflow.
- R5: Operand values driven outside the N beats of a multiply do not affect any result. Sums left over from an earlier multiply do not affect a later one.
- R6: A second multiply whose start comes 2N or more clocks after the first start gives correct results. Its results follow the R3 timing counted from its own start, while the first multiply's results are still being delivered.
- R7: Two `start` pulses are never closer together than 2N clocks. This is a rule on the caller.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | High in beat 0 of a multiply |
| a_col | input | N*DW | One column of A per beat, lane l = row l |
| b_row | input | N*DW | One row of B per beat, lane l = column l |
| c_out | output | N*AW | Result lanes, lane r = row r of C |
| c_valid | output | N | Per-lane flag: a result word is on that lane |

## Verification
Taking the start clock as clock 0, the element C[r][j] is due on lane r in clock r + N + 2j, and the lane must be idle in every other clock. For each clock of a run, the bench computes the set of lanes and values that are due. It samples on the falling edge, so the registers that feed the lanes have settled. It checks the valid bit of every lane and, where a word is due, its value. In the overlapped runs, the second start is offset by a known gap, so lanes from both multiplies are checked in the same clocks.

// File: rtl/mmgrid_pkg.sv
`timescale 1ns/1ps
package mmgrid_pkg;
   // Sum of n products of two dw-bit unsigned values fits in this many bits.
   function automatic int acc_width(input int dw, input int n);
      return 2 * dw + $clog2(n);
   endfunction
endpackage

// File: rtl/mm_delay.sv
`timescale 1ns/1ps
module mm_delay #(
   parameter int W = 1,
   parameter int D = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (D < 1) begin : g_bad_depth
      $error("mm_delay: D must be 1 or more");
   end

   logic [W-1:0] stage [D];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < D; k++) stage[k] <= '0;
      end else begin
         stage[0] <= d;
         for (int k = 1; k < D; k++) stage[k] <= stage[k-1];
      end
   end

   assign q = stage[D-1];
endmodule

// File: rtl/mm_mac_cell.sv
`timescale 1ns/1ps
module mm_mac_cell #(
   parameter int DW = 8,
   parameter int AW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  logic          first_i,
   input  logic          last_i,
   input  logic [AW-1:0] res_i,
   input  logic          rv_i,
   output logic [DW-1:0] a_o,
   output logic [DW-1:0] b_o,
   output logic          first_o,
   output logic          last_o,
   output logic [AW-1:0] res_o,
   output logic          rv_o
);
   if (AW < 2 * DW) begin : g_bad_width
      $error("mm_mac_cell: AW must hold a full product");
   end

   logic [2*DW-1:0] prod;
   logic [AW-1:0]   acc_q;
   logic [AW-1:0]   acc_nx;

   always_comb begin
      prod   = a_i * b_i;
      acc_nx = first_i ? AW'(prod) : acc_q + AW'(prod);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_o     <= '0;
         b_o     <= '0;
         first_o <= 1'b0;
         last_o  <= 1'b0;
         acc_q   <= '0;
         res_o   <= '0;
         rv_o    <= 1'b0;
      end else begin
         a_o     <= a_i;
         b_o     <= b_i;
         first_o <= first_i;
         last_o  <= last_i;
         acc_q   <= acc_nx;
         if (last_i) begin
            res_o <= acc_nx;
            rv_o  <= 1'b1;
         end else begin
            res_o <= res_i;
            rv_o  <= rv_i;
         end
      end
   end
endmodule

// File: rtl/systolic_mm_grid.sv
`timescale 1ns/1ps
module systolic_mm_grid
   import mmgrid_pkg::*;
#(
   parameter int  N  = 4,
   parameter int  DW = 8,
   localparam int AW = acc_width(DW, N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [N*DW-1:0] a_col,
   input  logic [N*DW-1:0] b_row,
   output logic [N*AW-1:0] c_out,
   output logic [N-1:0]    c_valid
);
   localparam int PW = DW + 2;

   if (N < 1 || N > 16) begin : g_bad_n
      $error("systolic_mm_grid: N must be 1..16");
   end
   if (DW < 1 || DW > 32) begin : g_bad_dw
      $error("systolic_mm_grid: DW must be 1..32");
   end

   // Tag for the final beat: start delayed by N-1 clocks.
   logic last_tag;
   if (N == 1) begin : g_last_direct
      assign last_tag = start;
   end else begin : g_last_dly
      mm_delay #(.W(1), .D(N-1)) u_last (
         .clk(clk), .rst_n(rst_n), .d(start), .q(last_tag));
   end

   // Edge skew: lane l enters the grid l clocks late.
   logic [PW-1:0] a_edge [N];
   logic [DW-1:0] b_edge [N];

   for (genvar l = 0; l < N; l++) begin : g_lane
      logic [PW-1:0] a_pk;
      assign a_pk = {start, last_tag, a_col[l*DW +: DW]};
      if (l == 0) begin : g_direct
         assign a_edge[l] = a_pk;
         assign b_edge[l] = b_row[l*DW +: DW];
      end else begin : g_skew
         mm_delay #(.W(PW), .D(l)) u_a (
            .clk(clk), .rst_n(rst_n), .d(a_pk), .q(a_edge[l]));
         mm_delay #(.W(DW), .D(l)) u_b (
            .clk(clk), .rst_n(rst_n), .d(b_row[l*DW +: DW]), .q(b_edge[l]));
      end
   end

   // Cell outputs, indexed [row][column].
   logic [DW-1:0] a_q   [N][N];
   logic [DW-1:0] b_q   [N][N];
   logic          fst_q [N][N];
   logic          lst_q [N][N];
   logic [AW-1:0] r_q   [N][N];
   logic          v_q   [N][N];

   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
         logic [DW-1:0] a_w;
         logic [DW-1:0] b_w;
         logic          f_w;
         logic          l_w;
         logic [AW-1:0] r_w;
         logic          v_w;

         if (c == 0) begin : g_from_edge
            assign {f_w, l_w, a_w} = a_edge[r];
         end else begin : g_from_left
            assign a_w = a_q[r][c-1];
            assign f_w = fst_q[r][c-1];
            assign l_w = lst_q[r][c-1];
         end

         if (r == 0) begin : g_from_top
            assign b_w = b_edge[c];
         end else begin : g_from_above
            assign b_w = b_q[r-1][c];
         end

         if (c == N-1) begin : g_chain_end
            assign r_w = '0;
            assign v_w = 1'b0;
         end else begin : g_chain_mid
            assign r_w = r_q[r][c+1];
            assign v_w = v_q[r][c+1];
         end

         mm_mac_cell #(.DW(DW), .AW(AW)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .a_i(a_w), .b_i(b_w), .first_i(f_w), .last_i(l_w),
            .res_i(r_w), .rv_i(v_w),
            .a_o(a_q[r][c]), .b_o(b_q[r][c]),
            .first_o(fst_q[r][c]), .last_o(lst_q[r][c]),
            .res_o(r_q[r][c]), .rv_o(v_q[r][c]));
      end

      assign c_out[r*AW +: AW] = r_q[r][0];
      assign c_valid[r]        = v_q[r][0];
   end
endmodule

// File: rtl/systolic_mm_grid_chk.sv
`timescale 1ns/1ps
module systolic_mm_grid_chk #(
   parameter int N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [N-1:0] c_valid
);
   localparam int MAXC = 8 * N;
   localparam int CW   = $clog2(MAXC + 1);

   // Clocks since the latest and the previous start, saturating.
   logic [CW-1:0] cyc_q;
   logic [CW-1:0] prev_q;
   logic          seen_q;

   function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
      return (int'(v) >= MAXC) ? v : v + 1'b1;
   endfunction

   function automatic logic due(input logic [CW-1:0] v, input int lane);
      int d;
      d = int'(v) - lane - N;
      return (d >= 0) && (d <= 2 * N - 2) && (d % 2 == 0);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= CW'(MAXC);
         prev_q <= CW'(MAXC);
         seen_q <= 1'b0;
      end else if (start) begin
         prev_q <= bump(cyc_q);
         cyc_q  <= CW'(1);
         seen_q <= 1'b1;
      end else begin
         cyc_q  <= bump(cyc_q);
         prev_q <= bump(prev_q);
      end
   end

   p_idle_before_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> (c_valid == '0));

   p_start_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (int'(cyc_q) >= 2 * N));

   for (genvar l = 0; l < N; l++) begin : g_lane_chk
      p_lane_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
         c_valid[l] |-> (due(cyc_q, l) || due(prev_q, l)));

      p_lane_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
         c_valid[l] |=> !c_valid[l]);
   end
endmodule

bind systolic_mm_grid systolic_mm_grid_chk #(.N(N)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .c_valid(c_valid));

// File: tb/tb_systolic_mm_grid.sv
`timescale 1ns/1ps
module tb_systolic_mm_grid;
   localparam int N  = 4;
   localparam int DW = 8;
   localparam int AW = mmgrid_pkg::acc_width(DW, N);
   localparam int MW = N * N * DW;

   // Element (r,c) sits at bits [(r*N+c)*DW +: DW].
   localparam logic [MW-1:0] TAB_A [4] = '{
      128'h01000000_00010000_00000100_00000001,
      128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
      128'h01234567_89ABCDEF_FEDCBA98_76543210,
      128'h00000000_00000000_00000000_00000000};
   localparam logic [MW-1:0] TAB_B [4] = '{
      128'h100F0E0D_0C0B0A09_08070605_04030201,
      128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
      128'h3C5A7E81_9966C3A5_0F1E2D4B_69788796,
      128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF};

   logic            clk = 1'b0;
   logic            rst_n;
   logic            start;
   logic [N*DW-1:0] a_col;
   logic [N*DW-1:0] b_row;
   logic [N*AW-1:0] c_out;
   logic [N-1:0]    c_valid;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] ma [2][N][N];
   logic [DW-1:0] mb [2][N][N];
   logic [AW-1:0] mc [2][N][N];

   always #5 clk = ~clk;

   systolic_mm_grid #(.N(N), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .a_col(a_col), .b_row(b_row), .c_out(c_out), .c_valid(c_valid));

   task automatic load(input int slot, input int idx);
      logic [AW-1:0] acc;
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            ma[slot][r][c] = TAB_A[idx][(r*N+c)*DW +: DW];
            mb[slot][r][c] = TAB_B[idx][(r*N+c)*DW +: DW];
         end
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            acc = '0;
            for (int k = 0; k < N; k++)
               acc += AW'(ma[slot][r][k]) * AW'(mb[slot][k][c]);
            mc[slot][r][c] = acc;
         end
   endtask

   task automatic drive_beat(input int slot, input int k);
      for (int l = 0; l < N; l++) begin
         a_col[l*DW +: DW] = ma[slot][l][k];
         b_row[l*DW +: DW] = mb[slot][k][l];
      end
   endtask

   task automatic drive_junk(input int t);
      for (int l = 0; l < N; l++) begin
         a_col[l*DW +: DW] = DW'(t * 37 + l * 11 + 5);
         b_row[l*DW +: DW] = DW'(t * 53 + l * 7 + 3);
      end
   endtask

   task automatic check_outputs(input int t, input bit two, input int gap, input string tag);
      for (int lane = 0; lane < N; lane++) begin
         logic          exp_v;
         logic [AW-1:0] exp_d;
         exp_v = 1'b0;
         exp_d = '0;
         for (int m = 0; m < 2; m++) begin
            int d;
            if (m == 1 && !two) continue;
            d = t - (m == 1 ? gap : 0) - lane - N;
            if (d >= 0 && d % 2 == 0 && d / 2 < N) begin
               exp_v = 1'b1;
               exp_d = mc[m][lane][d/2];
            end
         end
         checks++;
         if (c_valid[lane] !== exp_v) begin
            errors++;
            $display("FAIL R3 lane %0d clock %0d: valid=%0b expected %0b", lane, t, c_valid[lane], exp_v);
         end else if (exp_v) begin
            checks++;
            if (c_out[lane*AW +: AW] !== exp_d) begin
               errors++;
               $display("FAIL %s lane %0d clock %0d: data=%0d expected %0d",
                        tag, lane, t, c_out[lane*AW +: AW], exp_d);
            end
         end
      end
   endtask

   // One or two multiplies; clock 0 is the first start.
   task automatic run(input bit two, input int gap, input string tag);
      int total;
      total = (two ? gap : 0) + 4 * N + 2;
      for (int t = 0; t < total; t++) begin
         @(negedge clk);
         check_outputs(t, two, gap, tag);
         start = (t == 0) || (two && t == gap);
         if (t < N) drive_beat(0, t);
         else if (two && t >= gap && t < gap + N) drive_beat(1, t - gap);
         else drive_junk(t);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R3 watchdog: run still active, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      a_col = '0;
      b_row = '0;

      // R1: outputs quiet during reset
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         checks++;
         if (c_valid !== '0 || c_out !== '0) begin
            errors++;
            $display("FAIL R1 in reset: valid=%0h data=%0h expected 0 0", c_valid, c_out);
         end
      end
      rst_n = 1'b1;

      // R1: junk operands without start give no output
      for (int t = 0; t < 2 * N; t++) begin
         @(negedge clk);
         checks++;
         if (c_valid !== '0 || c_out !== '0) begin
            errors++;
            $display("FAIL R1 idle clock %0d: valid=%0h data=%0h expected 0 0", t, c_valid, c_out);
         end
         drive_junk(t + 100);
      end

      // Table walk: identity, all-ones (R4), mixed after all-ones (R5), zero A
      for (int idx = 0; idx < 4; idx++) begin
         load(0, idx);
         run(1'b0, 0, idx == 1 ? "R4" : (idx == 2 ? "R5" : "R2"));
      end

      // R6 R7: second start exactly 2N clocks after the first
      load(0, 2);
      load(1, 1);
      run(1'b1, 2 * N, "R6 R7");

      // R6: odd gap, overlapped drain again
      load(0, 1);
      load(1, 0);
      run(1'b1, 2 * N + 3, "R6");

      // R5: a single mixed multiply after the overlapped pair
      load(0, 2);
      run(1'b0, 0, "R5");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule